// File: doc/BRIEF.md
# Two-Thread Fetch Arbiter with Fewest-In-Flight Priority

This block decides, every cycle, which of two hardware threads owns the shared instruction-fetch slot of a simultaneously multithreaded front end. Each thread has its own program counter and its own count of instructions it has fetched but not yet retired or squashed. No fetch state is shared between the threads. A thread may fetch when it is active, not stalled, not being redirected, and still has room in its private half of a back-end queue whose total depth is a parameter.

When both threads may fetch, the one with fewer instructions in flight wins. This keeps back-end occupancy balanced between the threads. Equal counts are settled by a round-robin pointer, which moves only when it is used and then points at the thread that lost. A thread that fills its half of the queue stops fetching until entries return, and it can never borrow room from its partner. If only one thread is active, that thread gets every fetch cycle, as in a single-threaded front end.

The grant is combinational from the registered counts and the current control inputs. Program counters and counts update at the next clock edge.

Top module: `smt_fetch_arb`

## Requirements
- R1: After reset both in-flight counts are 0, both program counters equal RESET_VEC, and the round-robin pointer favours thread 0. With both threads active and idle, the first grant therefore goes to thread 0.
- R2: A thread is eligible in a cycle only if its active bit is 1, its stall bit is 0, its redirect bit is 0 and its in-flight count is below PART (QUEUE_DEPTH/2). An ineligible thread is never granted.
- R3: When both threads are eligible and their counts differ, the thread with the smaller count is granted.
- R4: When both threads are eligible with equal counts, the thread named by the round-robin pointer is granted and the pointer moves to the other thread. In every other cycle the pointer holds.
- R5: When exactly one thread is eligible, it is granted in every such cycle.
- R6: When no thread is eligible, fetch_valid is 0, fetch_grant is 2'b00 and neither program counter changes except by redirect.
- R7: fetch_grant is one-hot whenever fetch_valid is 1 (bit 0 = thread 0, bit 1 = thread 1). fetch_pc is the granted thread's PC. fetch_num equals min(FETCH_W, PART − count). At the next edge the granted PC advances by fetch_num×4 and the granted count rises by fetch_num.
- R8: Each cycle a thread's count falls by its commit_cnt input, saturating at 0.
- R9: A redirect loads the redirect target into that thread's PC at the next edge. In the same edge it lowers the count by the squash amount together with that cycle's commit amount, saturating at 0.
- R10: A thread's count never exceeds PART. A thread at PART cannot fetch, and this does not affect the other thread's eligibility.
- R11: A thread becomes eligible in the same cycle its active bit rises, with no start-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | 2 | Per-thread active flag |
| thr_stall | input | 2 | Per-thread fetch stall (e.g. cache miss) |
| redir_valid | input | 2 | Per-thread redirect request |
| redir_pc0 | input | PC_W | Redirect target, thread 0 |
| redir_pc1 | input | PC_W | Redirect target, thread 1 |
| squash_cnt0 | input | CNT_W | Entries squashed by a thread 0 redirect |
| squash_cnt1 | input | CNT_W | Entries squashed by a thread 1 redirect |
| commit_cnt0 | input | CNT_W | Entries retired by thread 0 this cycle |
| commit_cnt1 | input | CNT_W | Entries retired by thread 1 this cycle |
| fetch_valid | output | 1 | A thread is fetching this cycle |
| fetch_grant | output | 2 | One-hot granted thread |
| fetch_pc | output | PC_W | PC of the granted thread (0 when idle) |
| fetch_num | output | NUM_W | Instructions fetched this cycle (0 when idle) |

## Verification
A wrong in-flight count shows up at the ports in one of two ways. It can flip the winner of the next contested cycle, or it can change fetch_num once the thread is within FETCH_W entries of its partition limit. A wrong program counter shows up on fetch_pc the next time that thread is granted. A stuck or misplaced round-robin pointer swaps the winner of the next equal-count cycle. Because the expected grant, PC and fetch size are predicted every cycle from an independent model of counts and pointer, any such corruption is reported within the first cycle in which it can influence the outputs.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;

    localparam int NUM_THR = 2;

    typedef enum logic {
        THR0 = 1'b0,
        THR1 = 1'b1
    } thr_id_e;

    typedef struct packed {
        thr_id_e rr;
    } pick_st_t;

    function automatic thr_id_e thr_other(thr_id_e t);
        return (t == THR0) ? THR1 : THR0;
    endfunction

    function automatic logic [1:0] thr_onehot(thr_id_e t);
        return (t == THR0) ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/smt_fetch_ctx.sv
module smt_fetch_ctx #(
    parameter int              PC_W      = 32,
    parameter int              CNT_W     = 5,
    parameter int              NUM_W     = 3,
    parameter int              PART      = 16,
    parameter int              FETCH_W   = 4,
    parameter logic [PC_W-1:0] RESET_VEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             stall,
    input  logic             redir,
    input  logic [PC_W-1:0]  redir_pc,
    input  logic [CNT_W-1:0] squash,
    input  logic [CNT_W-1:0] commit,
    input  logic             granted,
    output logic [PC_W-1:0]  pc,
    output logic [CNT_W-1:0] cnt,
    output logic [NUM_W-1:0] room,
    output logic             elig
);
    localparam int SW = CNT_W + 2;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [CNT_W-1:0] cnt;
    } ctx_st_t;

    ctx_st_t st_q, st_d;
    logic [CNT_W-1:0] free_d;
    logic [SW-1:0]    dec_d, base_d;

    always_comb begin
        st_d   = st_q;
        free_d = CNT_W'(PART) - st_q.cnt;
        room   = (free_d >= CNT_W'(FETCH_W)) ? NUM_W'(FETCH_W) : NUM_W'(free_d);
        elig   = active && !stall && !redir && (st_q.cnt < CNT_W'(PART));

        dec_d  = SW'(commit) + (redir ? SW'(squash) : '0);
        base_d = (SW'(st_q.cnt) > dec_d) ? (SW'(st_q.cnt) - dec_d) : '0;
        if (granted) begin
            base_d = base_d + SW'(room);
        end
        st_d.cnt = CNT_W'(base_d);

        if (redir) begin
            st_d.pc = redir_pc;
        end else if (granted) begin
            st_d.pc = st_q.pc + (PC_W'(room) << 2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc  <= RESET_VEC;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc  = st_q.pc;
    assign cnt = st_q.cnt;

endmodule

// File: rtl/smt_fetch_pick.sv
module smt_fetch_pick
    import smt_fetch_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            elig,
    input  logic [1:0][CNT_W-1:0] cnt,
    output logic [1:0]            grant
);
    pick_st_t st_q, st_d;

    always_comb begin
        st_d  = st_q;
        grant = 2'b00;
        unique case (elig)
            2'b01: grant = 2'b01;
            2'b10: grant = 2'b10;
            2'b11: begin
                if (cnt[0] < cnt[1]) begin
                    grant = 2'b01;
                end else if (cnt[1] < cnt[0]) begin
                    grant = 2'b10;
                end else begin
                    grant   = thr_onehot(st_q.rr);
                    st_d.rr = thr_other(st_q.rr);
                end
            end
            default: grant = 2'b00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rr <= THR0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smt_fetch_arb.sv
module smt_fetch_arb
    import smt_fetch_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              QUEUE_DEPTH = 32,
    parameter int              FETCH_W     = 4,
    parameter logic [PC_W-1:0] RESET_VEC   = PC_W'(32'h0000_1000),
    localparam int             PART        = QUEUE_DEPTH / 2,
    localparam int             CNT_W       = $clog2(PART + 1),
    localparam int             NUM_W       = $clog2(FETCH_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       thr_active,
    input  logic [1:0]       thr_stall,
    input  logic [1:0]       redir_valid,
    input  logic [PC_W-1:0]  redir_pc0,
    input  logic [PC_W-1:0]  redir_pc1,
    input  logic [CNT_W-1:0] squash_cnt0,
    input  logic [CNT_W-1:0] squash_cnt1,
    input  logic [CNT_W-1:0] commit_cnt0,
    input  logic [CNT_W-1:0] commit_cnt1,
    output logic             fetch_valid,
    output logic [1:0]       fetch_grant,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [NUM_W-1:0] fetch_num
);
    logic [NUM_THR-1:0][PC_W-1:0]  ctx_pc;
    logic [NUM_THR-1:0][PC_W-1:0]  tgt_pc;
    logic [NUM_THR-1:0][CNT_W-1:0] ctx_cnt;
    logic [NUM_THR-1:0][CNT_W-1:0] sq_cnt;
    logic [NUM_THR-1:0][CNT_W-1:0] cm_cnt;
    logic [NUM_THR-1:0][NUM_W-1:0] ctx_room;
    logic [NUM_THR-1:0]            ctx_elig;
    logic [NUM_THR-1:0]            grant;

    assign tgt_pc = {redir_pc1, redir_pc0};
    assign sq_cnt = {squash_cnt1, squash_cnt0};
    assign cm_cnt = {commit_cnt1, commit_cnt0};

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        smt_fetch_ctx #(
            .PC_W     (PC_W),
            .CNT_W    (CNT_W),
            .NUM_W    (NUM_W),
            .PART     (PART),
            .FETCH_W  (FETCH_W),
            .RESET_VEC(RESET_VEC)
        ) u_ctx (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (thr_active[g]),
            .stall   (thr_stall[g]),
            .redir   (redir_valid[g]),
            .redir_pc(tgt_pc[g]),
            .squash  (sq_cnt[g]),
            .commit  (cm_cnt[g]),
            .granted (grant[g]),
            .pc      (ctx_pc[g]),
            .cnt     (ctx_cnt[g]),
            .room    (ctx_room[g]),
            .elig    (ctx_elig[g])
        );
    end

    smt_fetch_pick #(
        .CNT_W(CNT_W)
    ) u_pick (
        .clk  (clk),
        .rst_n(rst_n),
        .elig (ctx_elig),
        .cnt  (ctx_cnt),
        .grant(grant)
    );

    always_comb begin
        fetch_grant = grant;
        fetch_valid = |grant;
        fetch_pc    = '0;
        fetch_num   = '0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (grant[t]) begin
                fetch_pc  = ctx_pc[t];
                fetch_num = ctx_room[t];
            end
        end
    end

endmodule

// File: rtl/smt_fetch_arb_chk.sv
module smt_fetch_arb_chk #(
    parameter int PC_W  = 32,
    parameter int CNT_W = 5,
    parameter int NUM_W = 3,
    parameter int PART  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            active,
    input logic [1:0]            stall,
    input logic [1:0]            redir,
    input logic [1:0][PC_W-1:0]  tgt,
    input logic [1:0][PC_W-1:0]  pc,
    input logic [1:0][CNT_W-1:0] cnt,
    input logic                  valid,
    input logic [1:0]            grant,
    input logic [NUM_W-1:0]      num
);
    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $onehot(grant));

    assert_idle_nogrant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (grant == 2'b00));

    for (genvar i = 0; i < 2; i++) begin : g_chk
        localparam int J = 1 - i;

        assert_eligible_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (active[i] && !stall[i] && !redir[i]));

        assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[i] <= CNT_W'(PART));

        assert_fewer_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> !(active[J] && !stall[J] && !redir[J] && (cnt[J] < cnt[i])));

        assert_redirect_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
            redir[i] |=> (pc[i] == $past(tgt[i])));

        assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |=> (pc[i] == $past(pc[i]) + (PC_W'($past(num)) << 2)));

        assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!grant[i] && !redir[i]) |=> $stable(pc[i]));
    end

endmodule

bind smt_fetch_arb smt_fetch_arb_chk #(
    .PC_W (PC_W),
    .CNT_W(CNT_W),
    .NUM_W(NUM_W),
    .PART (PART)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .active(thr_active),
    .stall (thr_stall),
    .redir (redir_valid),
    .tgt   (tgt_pc),
    .pc    (ctx_pc),
    .cnt   (ctx_cnt),
    .valid (fetch_valid),
    .grant (fetch_grant),
    .num   (fetch_num)
);

// File: tb/smt_fetch_arb_tb.sv
module smt_fetch_arb_tb;
    localparam int          PC_W    = 32;
    localparam int          DEPTH   = 32;
    localparam int          FW      = 4;
    localparam int          PART    = DEPTH / 2;
    localparam int          CNT_W   = $clog2(PART + 1);
    localparam int          NUM_W   = $clog2(FW + 1);
    localparam logic [31:0] RST_VEC = 32'h0000_1000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       thr_active, thr_stall, redir_valid;
    logic [PC_W-1:0]  redir_pc0, redir_pc1;
    logic [CNT_W-1:0] squash_cnt0, squash_cnt1, commit_cnt0, commit_cnt1;
    logic             fetch_valid;
    logic [1:0]       fetch_grant;
    logic [PC_W-1:0]  fetch_pc;
    logic [NUM_W-1:0] fetch_num;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // staged stimulus and reference model
    logic [1:0] s_act, s_st, s_rd;
    int s_tgt[2], s_sq[2], s_cm[2];
    int m_cnt[2], m_pc[2], m_rr;

    always #10 clk = ~clk;

    smt_fetch_arb #(
        .PC_W(PC_W), .QUEUE_DEPTH(DEPTH), .FETCH_W(FW), .RESET_VEC(RST_VEC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .thr_active(thr_active), .thr_stall(thr_stall), .redir_valid(redir_valid),
        .redir_pc0(redir_pc0), .redir_pc1(redir_pc1),
        .squash_cnt0(squash_cnt0), .squash_cnt1(squash_cnt1),
        .commit_cnt0(commit_cnt0), .commit_cnt1(commit_cnt1),
        .fetch_valid(fetch_valid), .fetch_grant(fetch_grant),
        .fetch_pc(fetch_pc), .fetch_num(fetch_num)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        s_act = 2'b00; s_st = 2'b00; s_rd = 2'b00;
        for (int i = 0; i < 2; i++) begin
            s_tgt[i] = 0; s_sq[i] = 0; s_cm[i] = 0;
        end
    endtask

    task automatic do_reset();
        idle_inputs();
        @(negedge clk);
        rst_n = 1'b0;
        thr_active = 0; thr_stall = 0; redir_valid = 0;
        redir_pc0 = 0; redir_pc1 = 0;
        squash_cnt0 = 0; squash_cnt1 = 0; commit_cnt0 = 0; commit_cnt1 = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_pc[i] = RST_VEC;
        end
        m_rr = 0;
    endtask

    // one cycle: drive staged inputs, compare against model, advance model
    task automatic step(string tag);
        bit el[2];
        int win, num, room, dec, c;
        @(negedge clk);
        thr_active = s_act; thr_stall = s_st; redir_valid = s_rd;
        redir_pc0 = s_tgt[0]; redir_pc1 = s_tgt[1];
        squash_cnt0 = CNT_W'(s_sq[0]); squash_cnt1 = CNT_W'(s_sq[1]);
        commit_cnt0 = CNT_W'(s_cm[0]); commit_cnt1 = CNT_W'(s_cm[1]);
        #5;
        for (int i = 0; i < 2; i++)
            el[i] = s_act[i] && !s_st[i] && !s_rd[i] && (m_cnt[i] < PART);
        win = -1;
        if (el[0] && el[1]) begin
            if (m_cnt[0] < m_cnt[1]) win = 0;
            else if (m_cnt[1] < m_cnt[0]) win = 1;
            else begin win = m_rr; m_rr = 1 - m_rr; end
        end else if (el[0]) win = 0;
        else if (el[1]) win = 1;

        chk(tag, "fetch_valid", int'(fetch_valid), (win >= 0) ? 1 : 0);
        chk(tag, "fetch_grant", int'(fetch_grant), (win < 0) ? 0 : (1 << win));
        num = 0;
        if (win >= 0) begin
            room = PART - m_cnt[win];
            num  = (room < FW) ? room : FW;
            chk(tag, "fetch_pc", int'(fetch_pc), m_pc[win]);
            chk(tag, "fetch_num", int'(fetch_num), num);
        end
        for (int i = 0; i < 2; i++) begin
            dec = s_cm[i] + (s_rd[i] ? s_sq[i] : 0);
            c = m_cnt[i] - dec;
            if (c < 0) c = 0;
            if (win == i) c = c + num;
            m_cnt[i] = c;
            if (s_rd[i]) m_pc[i] = s_tgt[i];
            else if (win == i) m_pc[i] = m_pc[i] + num * 4;
        end
    endtask

    task automatic t_reset_R1();
        do_reset();
        #5;
        chk("R1", "idle valid", int'(fetch_valid), 0);
        s_act = 2'b11;
        step("R1");  // tie at reset -> thread 0 at RST_VEC
        step("R1");
    endtask

    task automatic t_single_R5_R11();
        do_reset();
        s_act = 2'b10; s_cm[1] = 4;
        repeat (6) step("R5");
        s_act = 2'b11;  // thread 0 starts: wins at once with count 0
        step("R11");
        step("R11");
    endtask

    task automatic t_tie_R4();
        do_reset();
        s_act = 2'b11; s_cm[0] = 4; s_cm[1] = 4;
        repeat (8) step("R4");
    endtask

    task automatic t_fewer_R3_R8();
        do_reset();
        s_act = 2'b11;
        repeat (4) step("R3");
        s_cm[0] = 3;
        repeat (4) step("R8");
        s_cm[0] = 31; s_cm[1] = 0;  // over-commit saturates at 0
        step("R8");
        s_cm[0] = 0;
        repeat (3) step("R3");
    endtask

    task automatic t_stall_R2_R6();
        do_reset();
        s_act = 2'b11; s_st = 2'b01;
        repeat (3) step("R2");
        s_st = 2'b11;
        repeat (3) step("R6");
        s_st = 2'b00; s_act = 2'b00;
        repeat (2) step("R6");
        s_act = 2'b11;
        step("R2");
    endtask

    task automatic t_full_R10();
        do_reset();
        s_act = 2'b01;
        repeat (5) step("R10");  // thread 0 fills to 16, then blocked
        s_act = 2'b11;
        repeat (5) step("R10");  // thread 1 still fetches
        s_cm[0] = 1;
        step("R10");
        s_cm[0] = 0;
        step("R10");  // partial group of 1 when room is 1
        repeat (3) step("R10");
    endtask

    task automatic t_redirect_R9();
        do_reset();
        s_act = 2'b11; s_cm[1] = 2;
        repeat (4) step("R9");
        s_rd = 2'b01; s_tgt[0] = 32'h0000_8000; s_sq[0] = 5; s_cm[0] = 1;
        step("R9");
        s_rd = 2'b00; s_cm[0] = 0;
        repeat (3) step("R9");
        s_rd = 2'b10; s_tgt[1] = 32'h0000_4400; s_sq[1] = 31;
        step("R9");
        s_rd = 2'b00;
        repeat (3) step("R9");
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset_R1();
        t_single_R5_R11();
        t_tie_R4();
        t_fewer_R3_R8();
        t_stall_R2_R6();
        t_full_R10();
        t_redirect_R9();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule